// File: doc/BRIEF.md
# Packet Buffer Port Controller

The controller owns one port of a dual-port line RAM and moves a single packet between that RAM and a pair of streaming interfaces. A host loads a 32-bit command word and pulses a one-cycle go strobe. The command selects one of three actions: clear, stream a packet out of the RAM, or store an incoming packet into it. A packet occupies an inclusive range of line addresses. When the first line is above the last line, the range wraps from the top line to line 0.

When it streams out, the block fetches lines ahead of the consumer. Every word it presents is valid, the first word carries a start flag and the word from the last line carries an end flag. A consumer may stall for any number of cycles. It may also take one word per cycle with no gaps. When it stores, the block raises ready and writes each accepted word to the next line. It stops at the last line, or earlier on an end-flagged word, or on a malformed start-and-end word that arrives mid-packet. The done and error results stay visible until the next command.

Top module: `pbuf_port`

## Requirements
- R1: The command word takes effect only in a cycle with `cmd_go` high. Bits [8:0] give the first line, bits [17:9] the last line and bits [21:18] the step (only 1 is supported). Bit 22 selects streaming out, bit 23 selects storing, and bit 24 selects clear. Clear has priority over streaming out, and streaming out has priority over storing. A go pulse with none of the three bits set leaves the block idle.
- R2: A go pulse with clear set drops any transfer in progress. From the next cycle, `out_ready`, `in_ready`, `done` and `error` are all low.
- R3: When streaming out, the block presents the lines from first to last in ascending order, wrapping from 511 to 0. The first word has flag bit 0 (start) set, the word from the last line has flag bit 1 (end) set, and the transfer then ends with `done` high.
- R4: A word is consumed in a cycle where `out_take` and `out_ready` are both high. While it is not consumed, the presented word and its flags stay unchanged for any number of stall cycles.
- R5: The RAM returns read data one cycle after an enabled read, and holds that data while its enable is low. After the first word, a consumer holding `out_take` high takes one word in every cycle, with no cycle where `out_ready` is low.
- R6: If `out_abort` is high while a word is consumed, the transfer ends after that word. `error` rises and `done` stays low.
- R7: When storing, `in_ready` rises after the go pulse. Each word accepted (`in_valid` and `in_ready` both high) is written to the next line in order, with wraparound. After the word for the last line is written, `in_ready` falls and `done` rises.
- R8: An accepted word with end flag (bit 1) set is stored, and it ends the store early with `done` high.
- R9: Once a store has ended, `in_valid` pulses write nothing to the RAM.
- R10: An accepted word with both start (bit 0) and end (bit 1) set, arriving after a word of the same packet was already stored, is not stored. It ends the store, and `error` rises.
- R11: `done` and `error` hold their value until the next go pulse, which clears them.
- R12: Flag bits 3 and 2 of `out_flags` are always zero, and `out_flags` is all zero while `out_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_word | input | 32 | Command: mode bits, step, last line, first line |
| cmd_go | input | 1 | One-cycle strobe that loads the command |
| done | output | 1 | Transfer finished normally (sticky) |
| error | output | 1 | Transfer ended by error (sticky) |
| ram_en | output | 1 | RAM port enable |
| ram_we | output | 1 | RAM port write enable |
| ram_addr | output | 9 | RAM line address |
| ram_wdata | output | 32 | Data written to the RAM |
| ram_rdata | input | 32 | Data read from the RAM |
| in_data | input | 32 | Incoming stream word |
| in_flags | input | 4 | Incoming flags: bit 0 start, bit 1 end |
| in_valid | input | 1 | Incoming write strobe |
| in_ready | output | 1 | Store mode is ready to accept a word |
| out_data | output | 32 | Outgoing stream word |
| out_flags | output | 4 | Outgoing flags: bit 0 start, bit 1 end |
| out_ready | output | 1 | An outgoing word is presented |
| out_take | input | 1 | Consumer read strobe |
| out_abort | input | 1 | Consumer error, ends the read with the current word |

## Verification
The bench streams out short ranges in three ways: with no stall, with a fixed number of stall cycles, and with a consumer that holds its strobe continuously. These separate handshake holding from prefetch throughput. Wrapped ranges and the whole 512-line range test the address rollover and the end flag on the last line. Stores are run to the last line, cut short by an end flag, broken by a mid-packet start-and-end word, and followed by extra strobes. Reading one line past each stored range back through the block then shows whether a word was stored that should not have been. Clear in the middle of a packet, a command word with several mode bits set, and a command with an abort show the command priority and that the result flags are sticky.

// File: rtl/pbuf_pkg.sv
package pbuf_pkg;

   typedef enum logic [1:0] {
      MODE_NONE,
      MODE_CLEAR,
      MODE_READ,
      MODE_WRITE
   } pbuf_mode_e;

   typedef enum logic [1:0] {
      RD_IDLE,
      RD_FETCH,
      RD_SHOW
   } pbuf_rd_st_e;

   typedef enum logic {
      WR_IDLE,
      WR_OPEN
   } pbuf_wr_st_e;

   localparam int SOP_BIT = 0;
   localparam int EOP_BIT = 1;

endpackage

// File: rtl/pbuf_cmd_dec.sv
module pbuf_cmd_dec
   import pbuf_pkg::*;
#(
   parameter int CTRL_W = 32,
   parameter int ADDR_W = 9,
   parameter int STEP_W = 4
) (
   input  logic [CTRL_W-1:0] cmd_word,
   output logic [ADDR_W-1:0] first_line,
   output logic [ADDR_W-1:0] last_line,
   output pbuf_mode_e        mode
);
   localparam int RD_POS  = 2*ADDR_W + STEP_W;
   localparam int WR_POS  = RD_POS + 1;
   localparam int CLR_POS = RD_POS + 2;

   logic unused_ok;
   assign unused_ok = ^cmd_word;

   assign first_line = cmd_word[ADDR_W-1:0];
   assign last_line  = cmd_word[2*ADDR_W-1:ADDR_W];

   always_comb begin
      if (cmd_word[CLR_POS])      mode = MODE_CLEAR;
      else if (cmd_word[RD_POS])  mode = MODE_READ;
      else if (cmd_word[WR_POS])  mode = MODE_WRITE;
      else                        mode = MODE_NONE;
   end
endmodule

// File: rtl/pbuf_rd_eng.sv
module pbuf_rd_eng
   import pbuf_pkg::*;
#(
   parameter int ADDR_W = 9
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic              kill,
   input  logic [ADDR_W-1:0] first_line,
   input  logic [ADDR_W-1:0] last_line,
   input  logic              take,
   input  logic              abort,
   output logic              ram_en,
   output logic [ADDR_W-1:0] ram_addr,
   output logic              ready,
   output logic              sop,
   output logic              eop,
   output logic              fin,
   output logic              fail
);
   pbuf_rd_st_e       st;
   logic [ADDR_W-1:0] cur, last_q;
   logic              sop_q;
   logic              at_last, show, hit;

   assign show    = (st == RD_SHOW);
   assign at_last = (cur == last_q);
   assign hit     = show && take;

   always_ff @(posedge clk) begin
      if (rst) begin
         st     <= RD_IDLE;
         cur    <= '0;
         last_q <= '0;
         sop_q  <= 1'b0;
      end else if (start) begin
         st     <= RD_FETCH;
         cur    <= first_line;
         last_q <= last_line;
         sop_q  <= 1'b1;
      end else if (kill) begin
         st <= RD_IDLE;
      end else begin
         case (st)
            RD_FETCH: st <= RD_SHOW;
            RD_SHOW: if (take) begin
               sop_q <= 1'b0;
               if (abort || at_last) st  <= RD_IDLE;
               else                  cur <= cur + ADDR_W'(1);
            end
            default: st <= RD_IDLE;
         endcase
      end
   end

   assign ready    = show;
   assign sop      = show && sop_q;
   assign eop      = show && at_last;
   assign fin      = hit && !abort && at_last;
   assign fail     = hit && abort;
   assign ram_en   = (st == RD_FETCH) || (hit && !abort && !at_last);
   assign ram_addr = (st == RD_FETCH) ? cur : cur + ADDR_W'(1);
endmodule

// File: rtl/pbuf_wr_eng.sv
module pbuf_wr_eng
   import pbuf_pkg::*;
#(
   parameter int ADDR_W = 9
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic              kill,
   input  logic [ADDR_W-1:0] first_line,
   input  logic [ADDR_W-1:0] last_line,
   input  logic              valid,
   input  logic              in_sop,
   input  logic              in_eop,
   output logic              ram_en,
   output logic [ADDR_W-1:0] ram_addr,
   output logic              ready,
   output logic              fin,
   output logic              fail
);
   pbuf_wr_st_e       st;
   logic [ADDR_W-1:0] cur, last_q;
   logic              started;
   logic              hit, bad, at_last;

   assign ready   = (st == WR_OPEN);
   assign hit     = ready && valid;
   assign at_last = (cur == last_q);
   assign bad     = hit && in_sop && in_eop && started;

   always_ff @(posedge clk) begin
      if (rst) begin
         st      <= WR_IDLE;
         cur     <= '0;
         last_q  <= '0;
         started <= 1'b0;
      end else if (start) begin
         st      <= WR_OPEN;
         cur     <= first_line;
         last_q  <= last_line;
         started <= 1'b0;
      end else if (kill) begin
         st <= WR_IDLE;
      end else if (hit) begin
         if (bad || in_eop || at_last) begin
            st <= WR_IDLE;
         end else begin
            cur     <= cur + ADDR_W'(1);
            started <= 1'b1;
         end
      end
   end

   assign ram_en   = hit && !bad;
   assign ram_addr = cur;
   assign fin      = hit && !bad && (in_eop || at_last);
   assign fail     = bad;
endmodule

// File: rtl/pbuf_port.sv
module pbuf_port
   import pbuf_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 9,
   parameter int FLAG_W = 4,
   parameter int STEP_W = 4,
   parameter int CTRL_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [CTRL_W-1:0] cmd_word,
   input  logic              cmd_go,
   output logic              done,
   output logic              error,
   output logic              ram_en,
   output logic              ram_we,
   output logic [ADDR_W-1:0] ram_addr,
   output logic [DATA_W-1:0] ram_wdata,
   input  logic [DATA_W-1:0] ram_rdata,
   input  logic [DATA_W-1:0] in_data,
   input  logic [FLAG_W-1:0] in_flags,
   input  logic              in_valid,
   output logic              in_ready,
   output logic [DATA_W-1:0] out_data,
   output logic [FLAG_W-1:0] out_flags,
   output logic              out_ready,
   input  logic              out_take,
   input  logic              out_abort
);
   localparam int CMD_BITS = 2*ADDR_W + STEP_W + 3;

   generate
      if (CTRL_W < CMD_BITS) begin : g_bad_ctrl
         $error("pbuf_port: CTRL_W too narrow for the command fields");
      end
      if (FLAG_W < 2) begin : g_bad_flag
         $error("pbuf_port: FLAG_W must hold start and end flags");
      end
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_size
         $error("pbuf_port: ADDR_W and DATA_W must be positive");
      end
   endgenerate

   logic [ADDR_W-1:0] first_line, last_line;
   pbuf_mode_e        mode;

   pbuf_cmd_dec #(.CTRL_W(CTRL_W), .ADDR_W(ADDR_W), .STEP_W(STEP_W)) i_dec (
      .cmd_word(cmd_word), .first_line(first_line), .last_line(last_line), .mode(mode)
   );

   logic go_rd, go_wr;
   assign go_rd = cmd_go && (mode == MODE_READ);
   assign go_wr = cmd_go && (mode == MODE_WRITE);

   logic              r_en, r_sop, r_eop, r_fin, r_fail;
   logic [ADDR_W-1:0] r_addr;

   pbuf_rd_eng #(.ADDR_W(ADDR_W)) i_rd (
      .clk(clk), .rst(rst), .start(go_rd), .kill(cmd_go),
      .first_line(first_line), .last_line(last_line),
      .take(out_take), .abort(out_abort),
      .ram_en(r_en), .ram_addr(r_addr), .ready(out_ready),
      .sop(r_sop), .eop(r_eop), .fin(r_fin), .fail(r_fail)
   );

   logic              w_en, w_fin, w_fail;
   logic [ADDR_W-1:0] w_addr;

   pbuf_wr_eng #(.ADDR_W(ADDR_W)) i_wr (
      .clk(clk), .rst(rst), .start(go_wr), .kill(cmd_go),
      .first_line(first_line), .last_line(last_line),
      .valid(in_valid), .in_sop(in_flags[SOP_BIT]), .in_eop(in_flags[EOP_BIT]),
      .ram_en(w_en), .ram_addr(w_addr), .ready(in_ready),
      .fin(w_fin), .fail(w_fail)
   );

   logic unused_ok;
   assign unused_ok = ^in_flags;

   always_ff @(posedge clk) begin
      if (rst) begin
         done  <= 1'b0;
         error <= 1'b0;
      end else if (cmd_go) begin
         done  <= 1'b0;
         error <= 1'b0;
      end else begin
         if (r_fin || w_fin)   done  <= 1'b1;
         if (r_fail || w_fail) error <= 1'b1;
      end
   end

   assign ram_en    = r_en || w_en;
   assign ram_we    = w_en;
   assign ram_addr  = w_en ? w_addr : r_addr;
   assign ram_wdata = in_data;
   assign out_data  = ram_rdata;

   generate
      if (FLAG_W > 2) begin : g_flag_pad
         assign out_flags[FLAG_W-1:2] = '0;
      end
   endgenerate
   assign out_flags[SOP_BIT] = r_sop;
   assign out_flags[EOP_BIT] = r_eop;
endmodule

// File: rtl/pbuf_port_chk.sv
module pbuf_port_chk #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 9,
   parameter int FLAG_W = 4,
   parameter int STEP_W = 4,
   parameter int CTRL_W = 32
) (
   input logic              clk,
   input logic              rst,
   input logic [CTRL_W-1:0] cmd_word,
   input logic              cmd_go,
   input logic              done,
   input logic              error,
   input logic              ram_en,
   input logic              ram_we,
   input logic [ADDR_W-1:0] ram_addr,
   input logic [DATA_W-1:0] ram_wdata,
   input logic [DATA_W-1:0] ram_rdata,
   input logic [DATA_W-1:0] in_data,
   input logic [FLAG_W-1:0] in_flags,
   input logic              in_valid,
   input logic              in_ready,
   input logic [DATA_W-1:0] out_data,
   input logic [FLAG_W-1:0] out_flags,
   input logic              out_ready,
   input logic              out_take,
   input logic              out_abort
);
   localparam int CLR_POS = 2*ADDR_W + STEP_W + 2;

   // R1
   modes_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
      !(out_ready && in_ready));

   // R2
   clear_idles_chk: assert property (@(posedge clk) disable iff (rst)
      (cmd_go && cmd_word[CLR_POS]) |=> (!out_ready && !in_ready && !done && !error));

   // R3
   sop_once_chk: assert property (@(posedge clk) disable iff (rst)
      (out_ready && out_take && !cmd_go) |=> !out_flags[0]);

   // R3
   eop_ends_chk: assert property (@(posedge clk) disable iff (rst)
      (out_ready && out_take && out_flags[1] && !cmd_go) |=> (!out_ready && (done || error)));

   // R4
   hold_word_chk: assert property (@(posedge clk) disable iff (rst)
      (out_ready && !out_take && !cmd_go) |=> (out_ready && $stable(out_flags) && $stable(out_data)));

   // R5
   prefetch_chk: assert property (@(posedge clk) disable iff (rst)
      (out_ready && out_take && !out_flags[1] && !out_abort) |-> (ram_en && !ram_we));

   // R9
   no_store_closed_chk: assert property (@(posedge clk) disable iff (rst)
      !in_ready |-> !ram_we);

   // R11
   done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      (done && !cmd_go) |=> done);

   // R11
   error_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      (error && !cmd_go) |=> error);

   // R12
   flags_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      !out_ready |-> (out_flags == '0));
endmodule

bind pbuf_port pbuf_port_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .FLAG_W(FLAG_W), .STEP_W(STEP_W), .CTRL_W(CTRL_W)
) i_chk (.*);

// File: tb/test_pbuf_port.sv
module test_pbuf_port;
   localparam int CLK_PERIOD = 10;
   localparam int LINES = 512;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] cmd_word = '0;
   logic        cmd_go = 1'b0;
   logic        done, error;
   logic        ram_en, ram_we;
   logic [8:0]  ram_addr;
   logic [31:0] ram_wdata;
   logic [31:0] ram_rdata = '0;
   logic [31:0] in_data = '0;
   logic [3:0]  in_flags = '0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [31:0] out_data;
   logic [3:0]  out_flags;
   logic        out_ready;
   logic        out_take = 1'b0;
   logic        out_abort = 1'b0;

   int n_chk = 0;
   int n_err = 0;
   bit finished = 0;

   logic [31:0] mem [LINES];
   logic [31:0] ref_mem [LINES];
   logic [31:0] exp_data_q [$];
   logic [3:0]  exp_flag_q [$];

   always #(CLK_PERIOD/2) clk = ~clk;

   pbuf_port i_pbuf_port (
      .clk(clk), .rst(rst), .cmd_word(cmd_word), .cmd_go(cmd_go),
      .done(done), .error(error),
      .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
      .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
      .in_data(in_data), .in_flags(in_flags), .in_valid(in_valid), .in_ready(in_ready),
      .out_data(out_data), .out_flags(out_flags), .out_ready(out_ready),
      .out_take(out_take), .out_abort(out_abort)
   );

   // RAM model: one-cycle read latency, output held while disabled
   always @(posedge clk) begin
      if (ram_en) begin
         if (ram_we) mem[ram_addr] <= ram_wdata;
         else        ram_rdata <= mem[ram_addr];
      end
   end

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Scoreboard monitor: compares every consumed word
   always @(negedge clk) begin
      if (!rst && out_take && out_ready) begin
         if (exp_data_q.size() == 0) begin
            check("R3", "unexpected word", out_data, 32'hDEAD);
         end else begin
            check("R3", "stream data", out_data, exp_data_q.pop_front());
            check("R12", "stream flags", {28'd0, out_flags}, {28'd0, exp_flag_q.pop_front()});
         end
      end
   end

   task automatic send_cmd(input bit clr, input bit wr, input bit rd,
                           input int first, input int last);
      cmd_word = {7'd0, clr, wr, rd, 4'd1, 9'(last), 9'(first)};
      cmd_go = 1'b1;
      @(posedge clk); #1;
      cmd_go = 1'b0;
   endtask

   // stop_k: index after which the read stops; use_abort raises out_abort there
   task automatic rd_pkt(input int first, input int last, input int waits,
                         input int stop_k, input bit use_abort, output int stalls);
      int n;
      n = ((last - first + LINES) % LINES) + 1;
      stalls = 0;
      send_cmd(0, 0, 1, first, last);
      for (int k = 0; k < n; k++) begin
         int line;
         int guard;
         line = (first + k) % LINES;
         guard = 0;
         while (!out_ready && guard < 50) begin
            out_take = 1'b0;
            @(posedge clk); #1;
            if (k > 0) stalls++;
            guard++;
         end
         exp_data_q.push_back(ref_mem[line]);
         exp_flag_q.push_back({2'b00, k == n - 1, k == 0});
         out_take = 1'b1;
         out_abort = use_abort && (k == stop_k);
         @(posedge clk); #1;
         if (waits > 0) begin
            out_take = 1'b0;
            out_abort = 1'b0;
            repeat (waits) @(posedge clk);
            #1;
         end
         if (k == stop_k) break;
      end
      out_take = 1'b0;
      out_abort = 1'b0;
   endtask

   task automatic wr_pkt(input int first, input int last, input int count,
                         input int eop_k, input int bad_k, input int base);
      send_cmd(0, 1, 0, first, last);
      for (int k = 0; k < count; k++) begin
         int guard;
         int line;
         guard = 0;
         line = (first + k) % LINES;
         while (!in_ready && guard < 20) begin
            @(posedge clk); #1;
            guard++;
         end
         in_data = 32'(base + k);
         in_flags = {2'b00, (k == eop_k) || (k == bad_k), (k == 0) || (k == bad_k)};
         in_valid = 1'b1;
         if (!(k == bad_k && k > 0)) ref_mem[line] = 32'(base + k);
         @(posedge clk); #1;
         in_valid = 1'b0;
         in_flags = '0;
      end
   endtask

   initial begin
      repeat (CLK_PERIOD * 15000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_err++;
         $display("FAIL R4 watchdog: actual=hung expected=complete");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      int st;
      for (int i = 0; i < LINES; i++) begin
         mem[i] = 32'hA500_0000 + 32'(i * 7);
         ref_mem[i] = mem[i];
      end
      repeat (4) @(posedge clk);
      #1 rst = 1'b0;
      @(posedge clk); #1;

      // reset state
      check("R2", "reset out_ready", {31'd0, out_ready}, 0);
      check("R2", "reset in_ready", {31'd0, in_ready}, 0);
      check("R11", "reset done/error", {30'd0, done, error}, 0);
      check("R12", "idle flags", {28'd0, out_flags}, 0);

      // R3 simple read, no stalls
      rd_pkt(5, 10, 0, -1, 0, st);
      check("R3", "done after read", {30'd0, done, error}, 32'b10);
      check("R3", "ready low after read", {31'd0, out_ready}, 0);

      // R4 read with stall cycles
      rd_pkt(5, 10, 2, -1, 0, st);
      check("R4", "done after stalled read", {31'd0, done}, 1);

      // R3 wraparound read
      rd_pkt(505, 3, 0, -1, 0, st);
      check("R3", "done after wrapped read", {31'd0, done}, 1);

      // R5 whole buffer, back to back
      rd_pkt(0, 511, 0, -1, 0, st);
      check("R5", "stall cycles in back-to-back read", 32'(st), 0);
      check("R5", "queue drained", 32'(exp_data_q.size()), 0);

      // R11 done sticky
      repeat (5) @(posedge clk); #1;
      check("R11", "done held", {31'd0, done}, 1);

      // R6 abort on third word with stalls
      rd_pkt(5, 10, 3, 2, 1, st);
      check("R6", "error after abort", {30'd0, done, error}, 32'b01);
      check("R6", "ready low after abort", {31'd0, out_ready}, 0);

      // R2 clear mid-read
      rd_pkt(100, 120, 0, 1, 0, st);
      check("R2", "read still open", {31'd0, out_ready}, 1);
      send_cmd(1, 0, 0, 0, 0);
      check("R2", "clear drops read", {30'd0, out_ready, in_ready}, 0);
      check("R2", "clear resets results", {30'd0, done, error}, 0);

      // R1 priority: clear over read, read over write
      send_cmd(1, 0, 1, 5, 10);
      repeat (3) @(posedge clk); #1;
      check("R1", "clear beats read", {30'd0, out_ready, in_ready}, 0);
      send_cmd(0, 1, 1, 5, 10);
      @(posedge clk); #1;
      check("R1", "read beats write", {30'd0, out_ready, in_ready}, 32'b10);
      send_cmd(0, 0, 0, 5, 10);
      repeat (3) @(posedge clk); #1;
      check("R1", "no mode stays idle", {30'd0, out_ready, in_ready}, 0);

      // R7 full store to last line
      wr_pkt(10, 15, 6, -1, -1, 32'h1000);
      check("R7", "done after store", {30'd0, done, error}, 32'b10);
      check("R7", "ready low after store", {31'd0, in_ready}, 0);
      rd_pkt(9, 16, 0, -1, 0, st);

      // R8 early end flag
      wr_pkt(45, 200, 5, 4, -1, 32'h2000);
      check("R8", "done after early end", {30'd0, done, error}, 32'b10);
      check("R8", "ready low after early end", {31'd0, in_ready}, 0);
      rd_pkt(45, 50, 0, -1, 0, st);

      // R9 extra strobes after the last line
      wr_pkt(20, 22, 3, -1, -1, 32'h3000);
      in_valid = 1'b1;
      in_data = 32'hBAD0_0000;
      for (int j = 0; j < 3; j++) begin
         @(negedge clk);
         check("R9", "no RAM write when closed", {31'd0, ram_we}, 0);
      end
      @(posedge clk); #1;
      in_valid = 1'b0;
      rd_pkt(20, 23, 0, -1, 0, st);

      // R10 start+end mid-packet
      wr_pkt(55, 200, 4, -1, 3, 32'h4000);
      check("R10", "error after bad word", {30'd0, done, error}, 32'b01);
      check("R10", "ready low after bad word", {31'd0, in_ready}, 0);
      rd_pkt(55, 58, 0, -1, 0, st);

      // R7 wraparound store, then read it back
      wr_pkt(508, 4, 9, -1, -1, 32'h5000);
      check("R7", "done after wrapped store", {31'd0, done}, 1);
      rd_pkt(506, 10, 0, -1, 0, st);

      // R11 go clears results
      send_cmd(1, 0, 0, 0, 0);
      check("R11", "go clears done", {30'd0, done, error}, 0);

      repeat (5) @(posedge clk); #1;
      check("R3", "all words consumed", 32'(exp_data_q.size()), 0);
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule